// File: doc/BRIEF.md
# HDLC Transmit Flag and Bit-Stuffing Serializer

This block drives the transmit line of an HDLC serial port. A source hands it payload bytes over a valid/ready handshake, marking the final byte of each frame. The block turns these bytes into a continuous bit stream. Each frame is wrapped between an opening flag and a closing flag, the payload gets zero-bit insertion, and whole flags fill the line whenever no frame is ready. The source supplies any check bytes inside the payload, because the block computes none.

Three static configuration inputs shape the line. A 4-bit count sets the minimum number of idle flags between frames. A sharing switch lets one flag close one frame and open the next. A width switch selects one or four line bits per clock. A frame is opened only once the gap since the previous closing flag has reached its target, and then only if a byte is waiting. After reset the block behaves as if a frame had just closed. If the next byte of a frame is missing when the previous one finishes, the frame is closed with a flag.

Top module: `hdlc_flag_tx`

## Requirements
- R1: After reset `in_ready` is 1 and the line starts with a whole flag, the pattern 0x7E, sent least significant bit first.
- R2: With sharing off, exactly `cfg_nof` + 2 flags (closing, `cfg_nof` idle, opening) separate consecutive frames when the next frame's first byte is already waiting. The same number of flags precedes the first frame after reset.
- R3: With sharing on and `cfg_nof` = 0, exactly one flag separates back-to-back frames and serves as both the closing and the opening flag.
- R4: With sharing on and `cfg_nof` = k > 0, k − 1 idle flags are inserted, so the line carries k + 1 flags between consecutive frames.
- R5: Inside a frame, a 0 is inserted after every run of five consecutive 1 bits, including a run that ends on the frame's last bit. Runs continue across byte boundaries. Flags are never stuffed.
- R6: With `cfg_nibble` = 0 one line bit is sent per clock on `tx_bits[0]`, and `tx_bits[3:1]` are 0. Each byte is sent LSB first.
- R7: With `cfg_nibble` = 1 four line bits are sent per clock. The earliest of the four is on `tx_bits[0]` and the latest on `tx_bits[3]`, so the bit order is the same as in R6.
- R8: When no frame is pending the line carries back-to-back flags with no other bits between them.
- R9: `in_ready` is low while a byte is held and not yet taken by the serializer. Every byte accepted is transmitted exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nof | input | 4 | Minimum interframe flag count, 0 to 15 (static) |
| cfg_share | input | 1 | Shared closing/opening flag mode (static) |
| cfg_nibble | input | 1 | 0: one bit per clock, 1: four bits per clock (static) |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte ends its frame |
| in_ready | output | 1 | Block can take a byte this clock |
| tx_bits | output | 4 | Line bits for this clock, earliest in bit 0 |

## Verification
A wrong flag counter moves the frame start by a multiple of eight line bits. The first payload bit after reset or after a closing flag then appears early or late, and the bench catches this within the first frame. A broken run counter adds or drops a stuffed zero, which shifts every later bit. The fault therefore shows at the first byte containing five ones. A holding register that loses or repeats a byte turns up as a payload mismatch, or as a wrong handshake count by the end of the run. Nibble lane ordering faults scramble the stream within the first clock.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W  = 8;
  localparam int NOF_W   = 4;
  localparam int OUT_W   = 4;
  localparam int RUN_MAX = 5;
  localparam int LEFT_W  = $clog2(BYTE_W + 1);
  localparam int CNT_W   = NOF_W + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;

  typedef struct packed {
    logic              in_frame;
    logic              last;
    logic [BYTE_W-1:0] sh;
    logic [LEFT_W-1:0] left;
    logic [RUN_W-1:0]  run;
    logic [CNT_W-1:0]  fcnt;
  } tx_state_t;

  // total flags on the line between the last data bit and the next first data bit
  function automatic logic [CNT_W-1:0] flags_needed(logic [NOF_W-1:0] nof, logic share);
    return share ? CNT_W'(nof) + CNT_W'(1) : CNT_W'(nof) + CNT_W'(2);
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] c);
    return (&c) ? c : c + CNT_W'(1);
  endfunction

  function automatic tx_state_t idle_state();
    tx_state_t s;
    s.in_frame = 1'b0;
    s.last     = 1'b0;
    s.sh       = FLAG_PAT;
    s.left     = LEFT_W'(BYTE_W);
    s.run      = '0;
    s.fcnt     = '0;
    return s;
  endfunction
endpackage

// File: rtl/hdlc_tx_hold.sv
module hdlc_tx_hold
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              take,
  output logic              full_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              last_o
);
  logic              full_q;
  logic [BYTE_W-1:0] data_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
      last_q <= in_last;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready = !full_q;
  assign full_o   = full_q;
  assign data_o   = data_q;
  assign last_o   = last_q;

  // R9: a held byte is neither dropped nor altered until the serializer takes it
  a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(data_q) && $stable(last_q)));
endmodule

// File: rtl/hdlc_tx_lane.sv
module hdlc_tx_lane
  import hdlc_tx_pkg::*;
(
  input  tx_state_t         cur,
  input  logic              hold_ok,
  input  logic [BYTE_W-1:0] hold_data,
  input  logic              hold_last,
  input  logic [CNT_W-1:0]  need,
  output tx_state_t         nxt,
  output logic              bit_o,
  output logic              take_o,
  output logic              start_o
);
  logic [CNT_W-1:0] done_cnt;

  always_comb begin
    nxt      = cur;
    bit_o    = 1'b0;
    take_o   = 1'b0;
    start_o  = 1'b0;
    done_cnt = sat_inc(cur.fcnt);
    if (cur.in_frame && cur.run == RUN_W'(RUN_MAX)) begin
      nxt.run = '0;                              // stuffed zero
    end else begin
      if (cur.left == '0) begin
        if (cur.in_frame && !cur.last && hold_ok) begin
          nxt.sh   = hold_data;
          nxt.last = hold_last;
          nxt.left = LEFT_W'(BYTE_W);
          take_o   = 1'b1;
        end else if (cur.in_frame) begin
          nxt = idle_state();                    // closing flag
        end else if (done_cnt >= need && hold_ok) begin
          nxt.in_frame = 1'b1;
          nxt.sh       = hold_data;
          nxt.last     = hold_last;
          nxt.left     = LEFT_W'(BYTE_W);
          nxt.run      = '0;
          take_o       = 1'b1;
          start_o      = 1'b1;
        end else begin
          nxt.sh   = FLAG_PAT;
          nxt.left = LEFT_W'(BYTE_W);
          nxt.fcnt = done_cnt;
        end
      end
      bit_o    = nxt.sh[0];
      nxt.sh   = nxt.sh >> 1;
      nxt.left = nxt.left - LEFT_W'(1);
      if (nxt.in_frame) nxt.run = bit_o ? nxt.run + RUN_W'(1) : '0;
    end
  end
endmodule

// File: rtl/hdlc_flag_tx.sv
module hdlc_flag_tx
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NOF_W-1:0]  cfg_nof,
  input  logic              cfg_share,
  input  logic              cfg_nibble,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic [OUT_W-1:0]  tx_bits
);
  tx_state_t         st;
  tx_state_t         chain [OUT_W+1];
  logic              hok   [OUT_W];
  logic [OUT_W-1:0]  lane_bits;
  logic [OUT_W-1:0]  lane_take;
  logic [OUT_W-1:0]  lane_start;
  logic              hold_full;
  logic [BYTE_W-1:0] hold_data;
  logic              hold_last;
  logic [CNT_W-1:0]  need;
  logic              take_used;
  logic              frame_start;
  tx_state_t         step_next;

  assign need = flags_needed(cfg_nof, cfg_share);

  hdlc_tx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .take(take_used),
    .full_o(hold_full), .data_o(hold_data), .last_o(hold_last)
  );

  assign chain[0] = st;

  for (genvar i = 0; i < OUT_W; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign hok[i] = hold_full;
    end else begin : g_rest
      assign hok[i] = hok[i-1] & ~lane_take[i-1];
    end
    hdlc_tx_lane u_lane (
      .cur(chain[i]), .hold_ok(hok[i]), .hold_data(hold_data),
      .hold_last(hold_last), .need(need), .nxt(chain[i+1]),
      .bit_o(lane_bits[i]), .take_o(lane_take[i]), .start_o(lane_start[i])
    );
  end

  assign take_used   = cfg_nibble ? |lane_take  : lane_take[0];
  assign frame_start = cfg_nibble ? |lane_start : lane_start[0];
  assign step_next   = cfg_nibble ? chain[OUT_W] : chain[1];
  assign tx_bits     = cfg_nibble ? lane_bits : {{(OUT_W-1){1'b0}}, lane_bits[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) st <= idle_state();
    else        st <= step_next;
  end

  // R1: the bit budget of the current byte or flag stays within one byte
  a_r1_left_range: assert property (@(posedge clk) disable iff (!rst_n)
    st.left <= LEFT_W'(BYTE_W));
  // R5: a sixth consecutive 1 is never reached inside a frame
  a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    st.run <= RUN_W'(RUN_MAX));
  // R9: the holding register is emptied by at most one lane per clock
  a_r9_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_take) <= 1);
  // R2: a frame opens only from the flag state held in the register
  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !st.in_frame);
endmodule

// File: tb/hdlc_flag_tx_test.sv
module hdlc_flag_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FLAG_B = 8'h7E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_nof = '0;
  logic       cfg_share = 1'b0;
  logic       cfg_nibble = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [3:0] tx_bits;

  int checks = 0, errors = 0, accepted = 0;
  bit finished = 0, upper_bad = 0;
  bit exp_q[$];
  int cat_q[$];
  bit got_q[$];

  logic [7:0] fr_data [6] = '{8'hFF, 8'hFF, 8'h7E, 8'h1F, 8'h00, 8'hF8};
  bit         fr_last [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  hdlc_flag_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_nof(cfg_nof), .cfg_share(cfg_share),
    .cfg_nibble(cfg_nibble), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .tx_bits(tx_bits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n && in_valid && in_ready) accepted++;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int gap_flags(int nof, bit share);
    int closing = 1;
    int opening = (share && nof == 0) ? 0 : 1;
    int inserted = share ? ((nof == 0) ? 0 : nof - 1) : nof;
    return closing + inserted + opening;
  endfunction

  task automatic push_flags(int n, int cat);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < 8; i++) begin exp_q.push_back(FLAG_B[i]); cat_q.push_back(cat); end
  endtask

  task automatic push_frame(int first, int count);
    int ones = 0;
    for (int k = first; k < first + count; k++)
      for (int i = 0; i < 8; i++) begin
        exp_q.push_back(fr_data[k][i]); cat_q.push_back(1);
        ones = fr_data[k][i] ? ones + 1 : 0;
        if (ones == 5) begin exp_q.push_back(1'b0); cat_q.push_back(1); ones = 0; end
      end
  endtask

  task automatic put(int k);
    @(negedge clk);
    in_valid = 1'b1; in_data = fr_data[k]; in_last = fr_last[k];
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_cfg(int nof, bit share, bit nib);
    int g, w, ncyc;
    int bad [3];
    int first_bad [3];
    string gap_req;
    bit lead_ok;
    cfg_nof = 4'(nof); cfg_share = share; cfg_nibble = nib;
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete(); cat_q.delete(); got_q.delete();
    g = gap_flags(nof, share);
    push_flags(g, 0); push_frame(0, 3);
    push_flags(g, 0); push_frame(3, 1);
    push_flags(g, 0); push_frame(4, 2);
    push_flags(g, 0); push_flags(6, 2);
    accepted = 0; upper_bad = 0;
    w = nib ? 4 : 1;
    ncyc = (exp_q.size() + w - 1) / w;
    rst_n = 1'b1;
    check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    fork
      begin
        for (int c = 0; c < ncyc; c++) begin
          if (nib) for (int i = 0; i < 4; i++) got_q.push_back(tx_bits[i]);
          else begin
            got_q.push_back(tx_bits[0]);
            if (tx_bits[3:1] != 3'b000) upper_bad = 1;
          end
          @(negedge clk);
        end
      end
      begin
        for (int k = 0; k < 6; k++) put(k);
        @(negedge clk); in_valid = 1'b0;
      end
    join
    in_valid = 1'b0;
    for (int j = 0; j < 3; j++) begin bad[j] = 0; first_bad[j] = -1; end
    for (int i = 0; i < exp_q.size(); i++)
      if (got_q[i] !== exp_q[i]) begin
        if (first_bad[cat_q[i]] < 0) first_bad[cat_q[i]] = i;
        bad[cat_q[i]]++;
      end
    lead_ok = 1;
    for (int i = 0; i < 8; i++) if (got_q[i] !== FLAG_B[i]) lead_ok = 0;
    check(lead_ok, "R1", "first line byte is flag", int'(lead_ok), 1);
    gap_req = share ? ((nof == 0) ? "R3" : "R4") : "R2";
    check(bad[0] == 0, gap_req, $sformatf("gap flags nof=%0d share=%0d nib=%0d first bad bit", nof, share, nib),
          first_bad[0], -1);
    check(bad[1] == 0, "R5", $sformatf("stuffed payload nof=%0d share=%0d nib=%0d first bad bit", nof, share, nib),
          first_bad[1], -1);
    check(bad[2] == 0, "R8", "idle flags first bad bit", first_bad[2], -1);
    if (nib) check(bad[0] + bad[1] + bad[2] == 0, "R7", "nibble stream mismatching bits",
                   bad[0] + bad[1] + bad[2], 0);
    else begin
      check(bad[0] + bad[1] + bad[2] == 0, "R6", "serial stream mismatching bits",
            bad[0] + bad[1] + bad[2], 0);
      check(!upper_bad, "R6", "upper bits in serial mode", int'(upper_bad), 0);
    end
    check(accepted == 6, "R9", "bytes accepted", accepted, 6);
  endtask

  initial begin
    int nofs [5] = '{0, 1, 2, 3, 15};
    for (int nb = 0; nb < 2; nb++)
      for (int sh = 0; sh < 2; sh++)
        for (int n = 0; n < 5; n++)
          run_cfg(nofs[n], sh[0], nb[0]);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule